// File: doc/BRIEF.md
# Pixel Path Readback and ID Sequencer

This block gives a host processor a way to look at the colour data a palette-based video DAC is about to convert. The host writes a 3-bit mode code, and each host read that follows returns one byte. The byte is either a fixed identification value or one of the red, green and blue components of the palette output word. Those components are taken after the palette lookup and before any output width-shift stage. Each read moves an internal channel pointer forward. The order is red, then green, then blue, and then back to red. The identification byte is only reachable right after its code is written. Once the pointer has left it, the pointer never returns to it on its own.

The palette word is sampled into a holding register on the clock edge that sees the read strobe. The host side must keep the pixel data steady across the read, either by slowing the dot clock or by showing a uniform run of pixels. Codes with bit 2 set belong to other test functions. Under this block they make the pointer idle, and reads then return zero.

Top module: `pixpath_readback`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears `host_dout` to 0x00 and leaves the block idle, so a read before any code write returns 0x00.
- R2: Writing code 000 (bits 2:0 of `host_din`) starts the pointer at red. Successive reads return red (`pixel_word[23:16]`), green (`[15:8]`), blue (`[7:0]`) and then red again.
- R3: Writing code 001 starts the pointer at green, so three reads return green, blue, red.
- R4: Writing code 010 starts the pointer at blue, and the read after blue returns red.
- R5: Writing code 011 makes the next read return the identification byte 0x76. Six reads in a row return ID, red, green, blue, red, green.
- R6: After the pointer leaves the identification state, further reads never return it. Writing 011 again restores it for the next read.
- R7: Codes 100 through 111 make the block idle. Each read then returns 0x00 and the pointer does not move.
- R8: `host_dout` changes only on a read cycle. Changes on `pixel_word` without a read do not alter it.
- R9: When `host_wr` and `host_rd` are high in the same cycle, the write takes effect and the read is dropped. `host_dout` keeps its value, and the next read starts at the newly written position.
- R10: Only bits 2:0 of `host_din` are decoded on a write. Bits 7:3 have no effect, so 0xF9 acts as 001.
- R11: The identification byte is 0x76 whatever value `pixel_word` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the host access logic |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Mode-code write strobe, one cycle |
| host_rd | input | 1 | Readback strobe, one cycle |
| host_din | input | 8 | Write data; bits 2:0 hold the mode code |
| pixel_word | input | 3*CHW (24) | Palette output word: red high, green middle, blue low |
| host_dout | output | 8 | Byte returned by the most recent read |

## Verification
Some properties are checked by assertions on every cycle. These are that the output holds steady when no read is accepted, that it is zero straight after reset, and that a read that immediately follows a write returns the right first byte: the ID value, the green lane, or zero for an idle code. The full pointer walks need the bench's directed scenarios. These are the wrap from blue to red, the six-read run starting from the ID, and the rule that the ID never comes back without a rewrite. The scenarios also cover the dropped read when write and read collide, and the masking of the upper write bits.

// File: rtl/pixpath_readback.sv
module pixpath_readback #(
  parameter int          CHW     = 8,
  parameter logic [7:0]  ID_BYTE = 8'h76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_din,
  input  logic [3*CHW-1:0] pixel_word,
  output logic [7:0]       host_dout
);

  localparam int WORD_W = 3 * CHW;

  typedef enum logic [1:0] {
    P_RED = 2'd0,
    P_GRN = 2'd1,
    P_BLU = 2'd2,
    P_ID  = 2'd3
  } ptr_t;

  ptr_t       ptr_q, ptr_nx;
  logic       active_q;
  logic [7:0] sel_byte;
  logic [7:0] dout_q;

  wire [CHW-1:0] red_lane = pixel_word[WORD_W-1 -: CHW];
  wire [CHW-1:0] grn_lane = pixel_word[2*CHW-1 -: CHW];
  wire [CHW-1:0] blu_lane = pixel_word[CHW-1:0];

  wire [4:0] unused_din_hi = host_din[7:3];

  always_comb begin
    case (ptr_q)
      P_RED:   begin sel_byte = 8'(red_lane); ptr_nx = P_GRN; end
      P_GRN:   begin sel_byte = 8'(grn_lane); ptr_nx = P_BLU; end
      P_BLU:   begin sel_byte = 8'(blu_lane); ptr_nx = P_RED; end
      default: begin sel_byte = ID_BYTE;      ptr_nx = P_RED; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ptr_q    <= P_RED;
      dout_q   <= 8'h00;
    end else if (host_wr) begin
      active_q <= ~host_din[2];
      ptr_q    <= host_din[2] ? P_RED : ptr_t'(host_din[1:0]);
    end else if (host_rd) begin
      dout_q <= active_q ? sel_byte : 8'h00;
      if (active_q) ptr_q <= ptr_nx;
    end
  end

  assign host_dout = dout_q;

endmodule

module pixpath_readback_chk #(
  parameter int         CHW     = 8,
  parameter logic [7:0] ID_BYTE = 8'h76
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_din,
  input logic [3*CHW-1:0] pixel_word,
  input logic [7:0]       host_dout
);

  wire [4:0] unused_din_hi = host_din[7:3];
  wire       unused_pix    = ^{pixel_word[3*CHW-1:2*CHW], pixel_word[CHW-1:0]};

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> host_dout == 8'h00); // R1

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$past(host_rd) || $past(host_wr))) |-> $stable(host_dout)); // R8

  AST_ID_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(host_rd && !host_wr)
     && $past(host_wr && host_din[2:0] == 3'b011, 2)) |-> host_dout == ID_BYTE); // R5

  AST_GREEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(host_rd && !host_wr)
     && $past(host_wr && host_din[2:0] == 3'b001, 2))
    |-> host_dout == 8'($past(pixel_word[2*CHW-1:CHW]))); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(host_rd && !host_wr)
     && $past(host_wr && host_din[2], 2)) |-> host_dout == 8'h00); // R7

endmodule

bind pixpath_readback pixpath_readback_chk #(.CHW(CHW), .ID_BYTE(ID_BYTE)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_din(host_din), .pixel_word(pixel_word), .host_dout(host_dout)
);

// File: tb/sim_pixpath_readback.sv
`timescale 1ns/1ps
module sim_pixpath_readback;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_din = 8'h00;
  logic [23:0] pixel_word = 24'h000000;
  logic [7:0]  host_dout;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pixpath_readback u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_din(host_din), .pixel_word(pixel_word), .host_dout(host_dout)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_din = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string req);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check(host_dout, exp, req);
  endtask

  task automatic t_reset;
    check(host_dout, 8'h00, "R1 dout after reset");
    rd_chk(8'h00, "R1 read before any write");
  endtask

  task automatic t_red_start;
    pixel_word = 24'hA1B2C3;
    wr(8'h00);
    rd_chk(8'hA1, "R2 red");
    rd_chk(8'hB2, "R2 green");
    rd_chk(8'hC3, "R2 blue");
    rd_chk(8'hA1, "R2 wrap red");
  endtask

  task automatic t_green_start;
    pixel_word = 24'h112233;
    wr(8'h01);
    rd_chk(8'h22, "R3 green");
    rd_chk(8'h33, "R3 blue");
    rd_chk(8'h11, "R3 red");
  endtask

  task automatic t_blue_start;
    pixel_word = 24'h5A6B7C;
    wr(8'h02);
    rd_chk(8'h7C, "R4 blue");
    rd_chk(8'h5A, "R4 red after blue");
  endtask

  task automatic t_id_seq;
    pixel_word = 24'h0F1E2D;
    wr(8'h03);
    rd_chk(8'h76, "R5 id");
    rd_chk(8'h0F, "R5 red");
    rd_chk(8'h1E, "R5 green");
    rd_chk(8'h2D, "R5 blue");
    rd_chk(8'h0F, "R5 red");
    rd_chk(8'h1E, "R5 green");
    rd_chk(8'h2D, "R6 blue no id");
    rd_chk(8'h0F, "R6 red not id");
    rd_chk(8'h1E, "R6 green not id");
    wr(8'h03);
    rd_chk(8'h76, "R6 id after rewrite");
  endtask

  task automatic t_idle_codes;
    pixel_word = 24'hFFEEDD;
    for (int c = 4; c < 8; c++) begin
      wr(8'(c));
      rd_chk(8'h00, "R7 idle read");
      rd_chk(8'h00, "R7 idle second read");
    end
    wr(8'h00);
    rd_chk(8'hFF, "R7 leaves idle on code 000");
  endtask

  task automatic t_hold;
    pixel_word = 24'h123456;
    wr(8'h00);
    rd_chk(8'h12, "R8 read red");
    pixel_word = 24'h9ABCDE;
    repeat (4) @(negedge clk);
    check(host_dout, 8'h12, "R8 hold without read");
    rd_chk(8'hBC, "R8 next read green");
  endtask

  task automatic t_collide;
    pixel_word = 24'h445566;
    wr(8'h00);
    rd_chk(8'h44, "R9 setup red");
    @(negedge clk); host_wr = 1'b1; host_rd = 1'b1; host_din = 8'h01;
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b0;
    check(host_dout, 8'h44, "R9 read dropped");
    rd_chk(8'h55, "R9 write took effect");
  endtask

  task automatic t_upper_bits;
    pixel_word = 24'h778899;
    wr(8'hF9);
    rd_chk(8'h88, "R10 F9 acts as 001");
    wr(8'hFA);
    rd_chk(8'h99, "R10 FA acts as 010");
  endtask

  task automatic t_id_pixel;
    pixel_word = 24'hFFFFFF;
    wr(8'h03);
    rd_chk(8'h76, "R11 id with all ones");
    pixel_word = 24'h000000;
    wr(8'hFB);
    rd_chk(8'h76, "R11 id with zeros");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_red_start;
    t_green_start;
    t_blue_start;
    t_id_seq;
    t_idle_codes;
    t_hold;
    t_collide;
    t_upper_bits;
    t_id_pixel;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule